// File: doc/BRIEF.md
# Processor Low-Power State Controller

This block sequences a processor core through its clock-control states. It runs on an always-on reference clock and decides from halt, stop-clock, sleep, bus-clock and snoop inputs which of six states the core is in. From that state it drives separate enables for the core clock and the second-level cache clock, and a flag that tells the bus side whether snoops may be accepted.

Sleep is reachable only through the grant state. While the clocks are stopped, system management, init and the two local interrupt lines are held in one-deep latches and handed to the core once, on its first cycle back in the running state. A snoop taken from the halted or grant state returns to the state it came from. Leaving the deepest state waits for a programmable number of reference-clock cycles for the PLL to relock. During that wait the cache clock stays gated.

Top module: `core_pwr_ctl`

## Requirements
- R1: After reset, `state` is 0 (run), both clock enables and `snoopOk` are 1, `wakeVec` is 0, and the clock-stop permission bit is 1. State codes: 0 run, 1 halted, 2 grant, 3 snoop, 4 sleep, 5 deep sleep.
- R2: `haltExec` in run moves to halted. In halted, any of `smiReq`, `initReq`, `nmiReq`, `intrReq`, `binitReq`, or a pending latched event, returns to run. `cpuReset` in halted returns to run at once.
- R3: In halted, `flushReq` raises `flushAck` in the same cycle, and the state stays halted.
- R4: `stopClkReq` in run or halted enters grant. Dropping it in grant returns to the state grant was entered from.
- R5: In grant, `binitReq`, `flushReq` and `cpuReset` neither change the state nor show up on `wakeVec`.
- R6: In grant, sleep and deep sleep, SMI, INIT, NMI and INTR are latched into `wakeVec` bits 0, 1, 2 and 3. Repeated assertions merge into one. The latched set appears on `wakeVec` for exactly one cycle, the first cycle in run, and is then cleared.
- R7: `snoopStart` in halted or grant enters snoop. `snoopDone` in snoop returns to that origin.
- R8: `sleepReq` moves grant to sleep only after it has been high for SLEEP_HOLD consecutive cycles in grant. It has no effect in run or halted. Dropping it in sleep returns to grant.
- R9: `busClkRun` low in sleep enters deep sleep. Sleep is re-entered after SETTLE_CYCLES consecutive cycles of `busClkRun` high, counted in deep sleep.
- R10: `cacheClkEn` is 0 throughout deep sleep, including the settling wait, and 1 in every other state.
- R11: When the permission bit (written through `cfgWe`/`cfgStopEn`) is 1, `coreClkEn` is 0 in grant, sleep and deep sleep. When it is 0, `coreClkEn` stays 1 there. `coreClkEn` is 1 in the other states.
- R12: `cpuReset` in sleep goes straight to run without passing through grant.
- R13: `snoopOk` is 0 in sleep and deep sleep and 1 in every other state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock |
| rstN | input | 1 | Asynchronous active-low controller reset |
| cpuReset | input | 1 | Processor reset request |
| haltExec | input | 1 | Halt-executed strobe |
| stopClkReq | input | 1 | Stop-clock request level |
| sleepReq | input | 1 | Sleep request level |
| busClkRun | input | 1 | Bus clock is running |
| snoopStart | input | 1 | Snoop start strobe |
| snoopDone | input | 1 | Snoop done strobe |
| smiReq | input | 1 | System management interrupt |
| initReq | input | 1 | Init request |
| nmiReq | input | 1 | Non-maskable interrupt |
| intrReq | input | 1 | Maskable interrupt |
| binitReq | input | 1 | Bus init request |
| flushReq | input | 1 | Cache flush request |
| cfgWe | input | 1 | Write strobe for the clock-stop permission bit |
| cfgStopEn | input | 1 | Value written to the permission bit |
| state | output | 3 | Current state code |
| coreClkEn | output | 1 | Core clock enable |
| cacheClkEn | output | 1 | Second-level cache clock enable |
| snoopOk | output | 1 | Snoops may be accepted |
| flushAck | output | 1 | Flush serviced in halted state |
| wakeVec | output | 4 | One-shot latched events {INTR, NMI, INIT, SMI} |

## Verification
The assertions assume that `stopClkReq`, `sleepReq` and `busClkRun` are levels sampled on the reference clock, and that the strobes are synchronous to it. They also assume that a deep-sleep exit happens only with the bus clock running on the cycle of the exit. The random stimulus keeps to this. Every input changes on the falling edge. The level inputs flip only now and then, so hold windows and settling waits are reached. Strobes such as `cpuReset` and `snoopDone` arrive with their own probabilities in any state, so the ignored cases in grant and the reset paths out of sleep both occur.

// File: rtl/pwr_ctl_pkg.sv
package pwr_ctl_pkg;

  typedef enum logic [2:0] {
    ST_RUN   = 3'd0,
    ST_HALT  = 3'd1,
    ST_GRANT = 3'd2,
    ST_SNOOP = 3'd3,
    ST_SLEEP = 3'd4,
    ST_DEEP  = 3'd5
  } pwrState_t;

  localparam int unsigned EV_W = 4;  // {intr, nmi, init, smi}

  typedef struct packed {
    logic capEn;      // clocks stopped: latch wake events
    logic deliver;    // running: present and clear latched events
    logic grantCnt;   // in grant: qualify sleep request
    logic deepCnt;    // in deep sleep: run settling timer
  } dpCtl_t;

endpackage

// File: rtl/pwr_ctl_fsm.sv
module pwr_ctl_fsm
  import pwr_ctl_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            cpuReset,
  input  logic            haltExec,
  input  logic            stopClkReq,
  input  logic            sleepReq,
  input  logic            busClkRun,
  input  logic            snoopStart,
  input  logic            snoopDone,
  input  logic [EV_W-1:0] evIn,
  input  logic            binitReq,
  input  logic            flushReq,
  input  logic            allowStop,
  input  logic            sleepQual,
  input  logic            settleDone,
  input  logic            pendAny,
  output pwrState_t       curState,
  output dpCtl_t          ctl,
  output logic            coreClkEn,
  output logic            cacheClkEn,
  output logic            snoopOk,
  output logic            flushAck
);

  pwrState_t nxtState, grantRet, nxtGrantRet, snpRet, nxtSnpRet;
  logic      wakeHit, clkStopped;

  assign wakeHit = (|evIn) | binitReq | pendAny;

  always_comb begin
    nxtState    = curState;
    nxtGrantRet = grantRet;
    nxtSnpRet   = snpRet;
    unique case (curState)
      ST_RUN: begin
        if (stopClkReq) begin
          nxtState    = ST_GRANT;
          nxtGrantRet = ST_RUN;
        end else if (haltExec) begin
          nxtState = ST_HALT;
        end
      end
      ST_HALT: begin
        if (cpuReset || wakeHit) begin
          nxtState = ST_RUN;
        end else if (stopClkReq) begin
          nxtState    = ST_GRANT;
          nxtGrantRet = ST_HALT;
        end else if (snoopStart) begin
          nxtState  = ST_SNOOP;
          nxtSnpRet = ST_HALT;
        end
      end
      ST_GRANT: begin
        if (!stopClkReq) begin
          nxtState = grantRet;
        end else if (snoopStart) begin
          nxtState  = ST_SNOOP;
          nxtSnpRet = ST_GRANT;
        end else if (sleepQual) begin
          nxtState = ST_SLEEP;
        end
      end
      ST_SNOOP: begin
        if (snoopDone) nxtState = snpRet;
      end
      ST_SLEEP: begin
        if (cpuReset)        nxtState = ST_RUN;
        else if (!sleepReq)  nxtState = ST_GRANT;
        else if (!busClkRun) nxtState = ST_DEEP;
      end
      ST_DEEP: begin
        if (settleDone) nxtState = ST_SLEEP;
      end
      default: nxtState = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curState <= ST_RUN;
      grantRet <= ST_RUN;
      snpRet   <= ST_HALT;
    end else begin
      curState <= nxtState;
      grantRet <= nxtGrantRet;
      snpRet   <= nxtSnpRet;
    end
  end

  assign clkStopped  = (curState == ST_GRANT) || (curState == ST_SLEEP) || (curState == ST_DEEP);
  assign ctl.capEn    = clkStopped;
  assign ctl.deliver  = (curState == ST_RUN);
  assign ctl.grantCnt = (curState == ST_GRANT);
  assign ctl.deepCnt  = (curState == ST_DEEP);

  assign coreClkEn  = !(clkStopped && allowStop);
  assign cacheClkEn = (curState != ST_DEEP);
  assign snoopOk    = !((curState == ST_SLEEP) || (curState == ST_DEEP));
  assign flushAck   = (curState == ST_HALT) && flushReq;

  // R8: sleep is only entered from grant
  assert_sleep_via_grant_R8: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_SLEEP && $past(curState) != ST_SLEEP)
      |-> ($past(curState) == ST_GRANT || $past(curState) == ST_DEEP));

  // R9: leaving deep sleep requires the bus clock to be running
  assert_deep_exit_busclk_R9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(curState) == ST_DEEP && curState == ST_SLEEP) |-> $past(busClkRun));

  // R7: snoop is left only on snoop done
  assert_snoop_exit_done_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(curState) == ST_SNOOP && curState != ST_SNOOP) |-> $past(snoopDone));

  // R4: grant is left towards run/halted only when stop-clock is released
  assert_grant_exit_stop_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(curState) == ST_GRANT && (curState == ST_RUN || curState == ST_HALT))
      |-> !$past(stopClkReq));

  // R12: reset in sleep lands in run directly
  assert_sleep_reset_R12: assert property (@(posedge clk) disable iff (!rstN)
    ($past(curState) == ST_SLEEP && $past(cpuReset)) |-> (curState == ST_RUN));

endmodule

// File: rtl/pwr_ctl_dp.sv
module pwr_ctl_dp
  import pwr_ctl_pkg::*;
#(
  parameter int unsigned SLEEP_HOLD    = 4,
  parameter int unsigned SETTLE_CYCLES = 100000
) (
  input  logic            clk,
  input  logic            rstN,
  input  dpCtl_t          ctl,
  input  logic            sleepReq,
  input  logic            busClkRun,
  input  logic [EV_W-1:0] evIn,
  input  logic            cfgWe,
  input  logic            cfgStopEn,
  output logic [EV_W-1:0] wakeVec,
  output logic            pendAny,
  output logic            sleepQual,
  output logic            settleDone,
  output logic            allowStop
);

  localparam int unsigned HOLD_W = $clog2(SLEEP_HOLD + 1);
  localparam int unsigned SET_W  = $clog2(SETTLE_CYCLES + 1);
  localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(SLEEP_HOLD - 1);
  localparam logic [SET_W-1:0]  SET_LAST  = SET_W'(SETTLE_CYCLES - 1);

  logic [EV_W-1:0]   pend;
  logic [HOLD_W-1:0] holdCnt;
  logic [SET_W-1:0]  setCnt;

  // one-deep event latches, one per wake source
  for (genvar i = 0; i < EV_W; i++) begin : g_evLatch
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            pend[i] <= 1'b0;
      else if (ctl.deliver) pend[i] <= 1'b0;
      else if (ctl.capEn)   pend[i] <= pend[i] | evIn[i];
    end
  end

  assign pendAny = |pend;
  assign wakeVec = ctl.deliver ? pend : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          holdCnt <= '0;
    else if (ctl.grantCnt && sleepReq)  holdCnt <= (holdCnt == HOLD_LAST) ? holdCnt : holdCnt + 1'b1;
    else                                holdCnt <= '0;
  end
  assign sleepQual = ctl.grantCnt && sleepReq && (holdCnt == HOLD_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          setCnt <= '0;
    else if (ctl.deepCnt && busClkRun)  setCnt <= (setCnt == SET_LAST) ? setCnt : setCnt + 1'b1;
    else                                setCnt <= '0;
  end
  assign settleDone = ctl.deepCnt && busClkRun && (setCnt == SET_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      allowStop <= 1'b1;
    else if (cfgWe) allowStop <= cfgStopEn;
  end

  // R6: latched events are presented for a single cycle only
  assert_wake_oneshot_R6: assert property (@(posedge clk) disable iff (!rstN)
    (|wakeVec) |=> (wakeVec == '0));

endmodule

// File: rtl/core_pwr_ctl.sv
module core_pwr_ctl
  import pwr_ctl_pkg::*;
#(
  parameter int unsigned SLEEP_HOLD    = 4,
  parameter int unsigned SETTLE_CYCLES = 100000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cpuReset,
  input  logic       haltExec,
  input  logic       stopClkReq,
  input  logic       sleepReq,
  input  logic       busClkRun,
  input  logic       snoopStart,
  input  logic       snoopDone,
  input  logic       smiReq,
  input  logic       initReq,
  input  logic       nmiReq,
  input  logic       intrReq,
  input  logic       binitReq,
  input  logic       flushReq,
  input  logic       cfgWe,
  input  logic       cfgStopEn,
  output logic [2:0] state,
  output logic       coreClkEn,
  output logic       cacheClkEn,
  output logic       snoopOk,
  output logic       flushAck,
  output logic [3:0] wakeVec
);

  pwrState_t       curState;
  dpCtl_t          ctl;
  logic [EV_W-1:0] evIn;
  logic            allowStop, sleepQual, settleDone, pendAny;

  assign evIn  = {intrReq, nmiReq, initReq, smiReq};
  assign state = curState;

  pwr_ctl_fsm u_fsm (
    .clk(clk), .rstN(rstN), .cpuReset(cpuReset), .haltExec(haltExec),
    .stopClkReq(stopClkReq), .sleepReq(sleepReq), .busClkRun(busClkRun),
    .snoopStart(snoopStart), .snoopDone(snoopDone), .evIn(evIn),
    .binitReq(binitReq), .flushReq(flushReq), .allowStop(allowStop),
    .sleepQual(sleepQual), .settleDone(settleDone), .pendAny(pendAny),
    .curState(curState), .ctl(ctl), .coreClkEn(coreClkEn),
    .cacheClkEn(cacheClkEn), .snoopOk(snoopOk), .flushAck(flushAck)
  );

  pwr_ctl_dp #(.SLEEP_HOLD(SLEEP_HOLD), .SETTLE_CYCLES(SETTLE_CYCLES)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .sleepReq(sleepReq),
    .busClkRun(busClkRun), .evIn(evIn), .cfgWe(cfgWe), .cfgStopEn(cfgStopEn),
    .wakeVec(wakeVec), .pendAny(pendAny), .sleepQual(sleepQual),
    .settleDone(settleDone), .allowStop(allowStop)
  );

endmodule

// File: tb/core_pwr_ctl_tb.sv
module core_pwr_ctl_tb;

  localparam int HOLD   = 4;
  localparam int SETTLE = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cpuReset = 0, haltExec = 0, stopClkReq = 0, sleepReq = 0, busClkRun = 1;
  logic snoopStart = 0, snoopDone = 0, smiReq = 0, initReq = 0, nmiReq = 0, intrReq = 0;
  logic binitReq = 0, flushReq = 0, cfgWe = 0, cfgStopEn = 1;
  logic [2:0] state;
  logic coreClkEn, cacheClkEn, snoopOk, flushAck;
  logic [3:0] wakeVec;

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model
  int mState = 0, mGrantRet = 0, mSnpRet = 1, mHold = 0, mSet = 0;
  logic [3:0] mPend = 0;
  bit mAllow = 1;

  core_pwr_ctl #(.SLEEP_HOLD(HOLD), .SETTLE_CYCLES(SETTLE)) u_dut (
    .clk(clk), .rstN(rstN), .cpuReset(cpuReset), .haltExec(haltExec),
    .stopClkReq(stopClkReq), .sleepReq(sleepReq), .busClkRun(busClkRun),
    .snoopStart(snoopStart), .snoopDone(snoopDone), .smiReq(smiReq),
    .initReq(initReq), .nmiReq(nmiReq), .intrReq(intrReq), .binitReq(binitReq),
    .flushReq(flushReq), .cfgWe(cfgWe), .cfgStopEn(cfgStopEn), .state(state),
    .coreClkEn(coreClkEn), .cacheClkEn(cacheClkEn), .snoopOk(snoopOk),
    .flushAck(flushAck), .wakeVec(wakeVec)
  );

  always #5 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit stopped(int s);
    return (s == 2) || (s == 4) || (s == 5);
  endfunction

  // compare all outputs against the model (called away from the edge)
  task automatic cmpAll();
    chk("R4 state", int'(state), mState);
    chk("R11 coreClkEn", int'(coreClkEn), (stopped(mState) && mAllow) ? 0 : 1);
    chk("R10 cacheClkEn", int'(cacheClkEn), (mState == 5) ? 0 : 1);
    chk("R13 snoopOk", int'(snoopOk), (mState == 4 || mState == 5) ? 0 : 1);
    chk("R6 wakeVec", int'(wakeVec), (mState == 0) ? int'(mPend) : 0);
    chk("R3 flushAck", int'(flushAck), (mState == 1 && flushReq) ? 1 : 0);
  endtask

  task automatic modelStep();
    int n = mState;
    logic [3:0] ev = {intrReq, nmiReq, initReq, smiReq};
    bit qual = (mState == 2) && sleepReq && (mHold == HOLD - 1);
    bit sdone = (mState == 5) && busClkRun && (mSet == SETTLE - 1);
    case (mState)
      0: if (stopClkReq) begin n = 2; mGrantRet = 0; end else if (haltExec) n = 1;
      1: if (cpuReset || (|ev) || binitReq || (|mPend)) n = 0;
         else if (stopClkReq) begin n = 2; mGrantRet = 1; end
         else if (snoopStart) begin n = 3; mSnpRet = 1; end
      2: if (!stopClkReq) n = mGrantRet;
         else if (snoopStart) begin n = 3; mSnpRet = 2; end
         else if (qual) n = 4;
      3: if (snoopDone) n = mSnpRet;
      4: if (cpuReset) n = 0; else if (!sleepReq) n = 2; else if (!busClkRun) n = 5;
      5: if (sdone) n = 4;
      default: n = 0;
    endcase
    if (mState == 0) mPend = 0; else if (stopped(mState)) mPend |= ev;
    mHold = (mState == 2 && sleepReq) ? ((mHold == HOLD - 1) ? mHold : mHold + 1) : 0;
    mSet  = (mState == 5 && busClkRun) ? ((mSet == SETTLE - 1) ? mSet : mSet + 1) : 0;
    if (cfgWe) mAllow = cfgStopEn;
    mState = n;
  endtask

  // inputs set at the falling edge; one clock; compare at the next falling edge
  task automatic tick();
    #1;
    chk("R3 flushAck", int'(flushAck), (mState == 1 && flushReq) ? 1 : 0);
    modelStep();
    @(posedge clk);
    @(negedge clk);
    cmpAll();
  endtask

  task automatic clrStrobes();
    cpuReset = 0; haltExec = 0; snoopStart = 0; snoopDone = 0;
    smiReq = 0; initReq = 0; nmiReq = 0; intrReq = 0;
    binitReq = 0; flushReq = 0; cfgWe = 0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd12345));
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1: reset values
    chk("R1 state", int'(state), 0);
    chk("R1 coreClkEn", int'(coreClkEn), 1);
    chk("R1 cacheClkEn", int'(cacheClkEn), 1);
    chk("R1 snoopOk", int'(snoopOk), 1);
    chk("R1 wakeVec", int'(wakeVec), 0);

    // R8: sleep request ignored in run
    sleepReq = 1; repeat (HOLD + 2) tick();
    chk("R8 ignored in run", int'(state), 0);
    sleepReq = 0;
    // R2: halt
    haltExec = 1; tick(); clrStrobes();
    chk("R2 halt", int'(state), 1);
    // R3: flush serviced, stays halted
    flushReq = 1; tick(); clrStrobes();
    chk("R3 stays halted", int'(state), 1);
    // R8: ignored in halted
    sleepReq = 1; repeat (HOLD + 2) tick();
    chk("R8 ignored in halted", int'(state), 1);
    sleepReq = 0;
    // R4: stop-clock from halted
    stopClkReq = 1; tick();
    chk("R4 grant", int'(state), 2);
    chk("R11 core gated", int'(coreClkEn), 0);
    // R5: ignored inputs in grant
    binitReq = 1; flushReq = 1; cpuReset = 1; tick(); clrStrobes();
    chk("R5 grant held", int'(state), 2);
    chk("R5 no wake", int'(wakeVec), 0);
    // R6: latch with repeats
    smiReq = 1; tick(); tick(); clrStrobes();
    nmiReq = 1; tick(); clrStrobes();
    stopClkReq = 0; tick();
    chk("R4 back to halted", int'(state), 1);
    tick();
    chk("R2 pending wakes", int'(state), 0);
    chk("R6 one-shot vec", int'(wakeVec), 4'b0101);
    tick();
    chk("R6 cleared", int'(wakeVec), 0);
    // R7: snoop from halted
    haltExec = 1; tick(); clrStrobes();
    snoopStart = 1; tick(); clrStrobes();
    chk("R7 snoop", int'(state), 3);
    snoopDone = 1; tick(); clrStrobes();
    chk("R7 back halted", int'(state), 1);
    intrReq = 1; tick(); clrStrobes();
    chk("R2 intr wakes", int'(state), 0);
    // R8/R9/R10/R13: sleep path
    stopClkReq = 1; tick();
    sleepReq = 1; repeat (HOLD - 1) tick();
    chk("R8 still grant", int'(state), 2);
    tick();
    chk("R8 sleep", int'(state), 4);
    chk("R13 no snoop", int'(snoopOk), 0);
    busClkRun = 0; tick();
    chk("R9 deep", int'(state), 5);
    chk("R10 cache off", int'(cacheClkEn), 0);
    busClkRun = 1; repeat (SETTLE - 1) tick();
    chk("R9 settling", int'(state), 5);
    chk("R10 cache off settling", int'(cacheClkEn), 0);
    tick();
    chk("R9 sleep again", int'(state), 4);
    chk("R10 cache on", int'(cacheClkEn), 1);
    sleepReq = 0; tick();
    chk("R8 sleep release", int'(state), 2);
    sleepReq = 1; repeat (HOLD) tick();
    cpuReset = 1; tick(); clrStrobes();
    chk("R12 reset from sleep", int'(state), 0);
    sleepReq = 0;
    // R11: permission bit cleared keeps core clock
    cfgWe = 1; cfgStopEn = 0; tick(); clrStrobes();
    tick();
    chk("R11 core kept", int'(coreClkEn), 1);
    stopClkReq = 0; tick();
    cfgWe = 1; cfgStopEn = 1; tick(); clrStrobes();

    // constrained random phase
    for (int i = 0; i < 4000; i++) begin
      clrStrobes();
      if ($urandom_range(99) < 6)  stopClkReq = ~stopClkReq;
      if ($urandom_range(99) < 10) sleepReq = ~sleepReq;
      if ($urandom_range(99) < 8)  busClkRun = ~busClkRun;
      haltExec   = ($urandom_range(99) < 15);
      snoopStart = ($urandom_range(99) < 8);
      snoopDone  = ($urandom_range(99) < 20);
      smiReq     = ($urandom_range(99) < 4);
      initReq    = ($urandom_range(99) < 4);
      nmiReq     = ($urandom_range(99) < 4);
      intrReq    = ($urandom_range(99) < 4);
      binitReq   = ($urandom_range(99) < 3);
      flushReq   = ($urandom_range(99) < 10);
      cpuReset   = ($urandom_range(99) < 2);
      cfgWe      = ($urandom_range(99) < 2);
      cfgStopEn  = $urandom_range(1);
      tick();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule